// File: doc/BRIEF.md
# Recent-Eviction Reuse Predictor for Cache Fill Insertion

This block advises a cache controller where to place a block that has just missed. It remembers, in a compact bit vector indexed by two hashes, the addresses of blocks the cache has recently thrown out. A block that comes back soon after being thrown out is judged to have high reuse and goes in at the most-recently-used end of the replacement stack; any other block is judged low reuse and goes in under a bimodal rule that puts it at the least-recently-used end nearly every time.

The controller pulses `evict_valid` with the victim's block address whenever it evicts, and `miss_valid` with the missing block address whenever it misses. One cycle after each miss the block returns a verdict. An eviction counter bounds how stale the remembered set can become: after as many evictions as the cache has blocks, the whole vector and the counter start again from empty. Membership is approximate; unrelated addresses may alias onto set bits, and no single address is ever withdrawn.

Top module: `reuse_insert_predictor`

## Requirements
- R1: After reset the filter holds no addresses, the eviction count is zero, `verdict_valid` is 0 and the bimodal generator holds its seed 16'hACE1.
- R2: Each cycle with `miss_valid` high produces exactly one cycle of `verdict_valid` high on the next cycle; with no miss, `verdict_valid`, `verdict_hit` and `insert_mru` are all 0.
- R3: The filter has `CACHE_BLOCKS*BITS_PER_ADDR` bits (a power of two, 512 by default) indexed by IDX_W bits. An address yields two indices: the address rotated left by `ROT_A` (7) and by `ROT_B` (19), each folded so that bit i of the rotated word is XORed into index bit i mod IDX_W.
- R4: An eviction sets both filter bits indexed by the evicted address, and those bits stay set until a clear.
- R5: A miss whose two indexed bits are both set gives `verdict_hit`=1 and `insert_mru`=1.
- R6: A miss with either indexed bit clear gives `verdict_hit`=0, and `insert_mru` follows the bimodal rule of R7.
- R7: The bimodal generator is a 16-bit shift register that on every miss shifts left taking in bit15^bit13^bit12^bit10 at bit 0; a low-reuse miss gets `insert_mru`=1 only when bits 4:0 of its value before that shift are all zero (one chance in 32).
- R8: Each eviction increments the count; the eviction that would bring the count to `CACHE_BLOCKS` instead clears the whole filter and the count, and its own address is not kept.
- R9: When an eviction and a miss share a cycle, the miss is tested against the filter as it stood before that eviction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| evict_valid | input | 1 | A block is evicted this cycle |
| evict_addr | input | ADDR_W | Block address of the victim |
| miss_valid | input | 1 | A block missed this cycle |
| miss_addr | input | ADDR_W | Block address that missed |
| verdict_valid | output | 1 | Verdict for the miss of the previous cycle |
| verdict_hit | output | 1 | The missed address was found among recent evictions |
| insert_mru | output | 1 | Insert the missed block at the MRU position |

## Verification
The hardest state to reach is the exact eviction that crosses the count limit, since the count is not visible at the ports. The bench starts from reset, evicts a known address, then feeds distinct addresses until exactly one eviction short of the limit, confirms that address is still found, and issues one more eviction before probing both the early address and the last one, which must now both be absent. Same-cycle eviction and miss of one address, and long runs of never-evicted misses that walk the bimodal generator through its rare MRU draws, are driven against a bench-side model of the hashed vector.

// File: rtl/reuse_insert_predictor.sv
module reuse_insert_predictor #(
  parameter int ADDR_W        = 32,
  parameter int CACHE_BLOCKS  = 64,
  parameter int BITS_PER_ADDR = 8,
  parameter int ROT_A         = 7,
  parameter int ROT_B         = 19
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evict_valid,
  input  logic [ADDR_W-1:0] evict_addr,
  input  logic              miss_valid,
  input  logic [ADDR_W-1:0] miss_addr,
  output logic              verdict_valid,
  output logic              verdict_hit,
  output logic              insert_mru
);
  localparam int FILTER_BITS = CACHE_BLOCKS * BITS_PER_ADDR;
  localparam int IDX_W       = $clog2(FILTER_BITS);
  localparam int CNT_W       = $clog2(CACHE_BLOCKS + 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(CACHE_BLOCKS - 1);
  localparam logic [15:0] SEED = 16'hACE1;

  function automatic logic [IDX_W-1:0] fold_idx(input logic [ADDR_W-1:0] a, input int rot);
    logic [ADDR_W-1:0] r;
    logic [IDX_W-1:0]  idx;
    r   = (rot == 0) ? a : ((a << rot) | (a >> (ADDR_W - rot)));
    idx = '0;
    for (int i = 0; i < ADDR_W; i++) idx[i % IDX_W] ^= r[i];
    return idx;
  endfunction

  logic [FILTER_BITS-1:0] filt;
  logic [CNT_W-1:0]       evict_cnt;
  logic [15:0]            lfsr;

  wire [IDX_W-1:0] ev_a = fold_idx(evict_addr, ROT_A);
  wire [IDX_W-1:0] ev_b = fold_idx(evict_addr, ROT_B);
  wire [IDX_W-1:0] ms_a = fold_idx(miss_addr, ROT_A);
  wire [IDX_W-1:0] ms_b = fold_idx(miss_addr, ROT_B);

  wire present  = filt[ms_a] & filt[ms_b];
  wire rare_mru = (lfsr[4:0] == 5'd0);
  wire [15:0] lfsr_nxt = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      filt      <= '0;
      evict_cnt <= '0;
    end else if (evict_valid) begin
      if (evict_cnt == LAST_CNT) begin
        filt      <= '0;
        evict_cnt <= '0;
      end else begin
        filt[ev_a] <= 1'b1;
        filt[ev_b] <= 1'b1;
        evict_cnt  <= evict_cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lfsr          <= SEED;
      verdict_valid <= 1'b0;
      verdict_hit   <= 1'b0;
      insert_mru    <= 1'b0;
    end else begin
      verdict_valid <= miss_valid;
      verdict_hit   <= miss_valid & present;
      insert_mru    <= miss_valid & (present | rare_mru);
      if (miss_valid) lfsr <= lfsr_nxt;
    end
  end
endmodule

module reuse_insert_predictor_chk #(
  parameter int CNT_W = 7,
  parameter int LIMIT = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             evict_valid,
  input logic             miss_valid,
  input logic             verdict_valid,
  input logic             verdict_hit,
  input logic             insert_mru,
  input logic [CNT_W-1:0] cnt
);
  p_verdict_timing_r2: assert property (@(posedge clk) disable iff (!rst_n)
    miss_valid |=> verdict_valid);
  p_no_spurious_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !miss_valid |=> !verdict_valid);
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !verdict_valid |-> (!verdict_hit && !insert_mru));
  p_hit_mru_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (verdict_valid && verdict_hit) |-> insert_mru);
  p_count_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < CNT_W'(LIMIT));
  p_count_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (evict_valid && cnt == CNT_W'(LIMIT - 1)) |=> (cnt == '0));
  p_count_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (evict_valid && cnt != CNT_W'(LIMIT - 1)) |=> (cnt == $past(cnt) + 1'b1));
  p_count_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !evict_valid |=> $stable(cnt));
endmodule

bind reuse_insert_predictor reuse_insert_predictor_chk #(.CNT_W(CNT_W), .LIMIT(CACHE_BLOCKS)) chk_i (
  .clk(clk), .rst_n(rst_n), .evict_valid(evict_valid), .miss_valid(miss_valid),
  .verdict_valid(verdict_valid), .verdict_hit(verdict_hit), .insert_mru(insert_mru),
  .cnt(evict_cnt)
);

// File: tb/reuse_insert_predictor_tb.sv
module reuse_insert_predictor_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int NBLK = 64;
  localparam int NBITS = NBLK * 8;
  localparam int IW = 9;

  logic clk = 1'b0, rst_n = 1'b0;
  logic evict_valid = 1'b0, miss_valid = 1'b0;
  logic [AW-1:0] evict_addr = '0, miss_addr = '0;
  logic verdict_valid, verdict_hit, insert_mru;

  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;

  bit    q_hit[$];
  bit    q_mru[$];
  string q_tag[$];

  bit [NBITS-1:0] m_filt;
  int             m_cnt;
  bit [15:0]      m_lfsr;

  always #(CLK_PERIOD/2) clk = ~clk;

  reuse_insert_predictor dut_i (
    .clk(clk), .rst_n(rst_n), .evict_valid(evict_valid), .evict_addr(evict_addr),
    .miss_valid(miss_valid), .miss_addr(miss_addr), .verdict_valid(verdict_valid),
    .verdict_hit(verdict_hit), .insert_mru(insert_mru)
  );

  // R3: rotate left then fold bit i into index bit i mod IW
  function automatic int hidx(input bit [AW-1:0] a, input int rot);
    bit [AW-1:0] r;
    int idx;
    r = (a << rot) | (a >> (AW - rot));
    idx = 0;
    for (int i = 0; i < AW; i++) if (r[i]) idx = idx ^ (1 << (i % IW));
    return idx;
  endfunction

  function automatic bit m_has(input bit [AW-1:0] a);
    return m_filt[hidx(a, 7)] && m_filt[hidx(a, 19)];
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(input bit ev, input bit [AW-1:0] ea, input bit ms,
                      input bit [AW-1:0] ma, input string tag);
    bit h;
    @(negedge clk);
    evict_valid = ev; evict_addr = ea; miss_valid = ms; miss_addr = ma;
    if (ms) begin
      h = m_has(ma); // R9: tested against the pre-eviction state
      q_hit.push_back(h);
      q_mru.push_back(h || (m_lfsr[4:0] == 5'd0));
      q_tag.push_back(tag);
      m_lfsr = {m_lfsr[14:0], m_lfsr[15] ^ m_lfsr[13] ^ m_lfsr[12] ^ m_lfsr[10]};
    end
    if (ev) begin
      if (m_cnt == NBLK - 1) begin m_filt = '0; m_cnt = 0; end
      else begin m_filt[hidx(ea, 7)] = 1'b1; m_filt[hidx(ea, 19)] = 1'b1; m_cnt++; end
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, '0, 1'b0, '0, "");
  endtask

  // monitor / scoreboard
  always @(posedge clk) begin
    #1;
    if (rst_n && verdict_valid) begin
      if (q_hit.size() == 0) check("R2 unexpected verdict", 1, 0);
      else begin
        string t;
        t = q_tag.pop_front();
        check({t, " hit"}, verdict_hit, q_hit.pop_front());
        check({t, " mru"}, insert_mru, q_mru.pop_front());
      end
    end else if (rst_n && !verdict_valid) begin
      if (verdict_hit || insert_mru) check("R2 quiet outputs", 1, 0);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: actual %0d expected 0", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    bit [AW-1:0] a;
    m_filt = '0; m_cnt = 0; m_lfsr = 16'hACE1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check("R1 reset verdict_valid", verdict_valid, 0);
    check("R1 reset insert_mru", insert_mru, 0);

    // R1/R6: empty filter gives absent
    step(1'b0, '0, 1'b1, 32'h0000_1234, "R1,R6 empty filter");
    // R4/R5: evict then miss same address
    step(1'b1, 32'h0000_1234, 1'b0, '0, "");
    step(1'b0, '0, 1'b1, 32'h0000_1234, "R4,R5 evicted found");
    // R9: same-cycle eviction and miss
    step(1'b1, 32'hDEAD_0040, 1'b1, 32'hDEAD_0040, "R9 same cycle absent");
    step(1'b0, '0, 1'b1, 32'hDEAD_0040, "R9 found next cycle");
    idle(2);

    // R8: walk the count to one short of the limit with distinct addresses
    a = 32'h7700_0000;
    while (m_cnt < NBLK - 1) begin step(1'b1, a, 1'b0, '0, ""); a = a + 32'h40; end
    step(1'b0, '0, 1'b1, 32'h0000_1234, "R8 kept before limit");
    step(1'b1, 32'h5555_AAAA, 1'b0, '0, "");
    step(1'b0, '0, 1'b1, 32'h0000_1234, "R8 cleared at limit");
    step(1'b0, '0, 1'b1, 32'h5555_AAAA, "R8 limit address not kept");
    idle(2);

    // R6/R7: long run of low-reuse misses through the bimodal draws
    for (int i = 0; i < 400; i++) step(1'b0, '0, 1'b1, 32'hB000_0000 + i * 32'h1040, "R6,R7 bimodal");
    idle(2);

    // R3/R4/R8/R9: random mix from a small pool
    for (int i = 0; i < 2000; i++)
      step($urandom_range(0, 1) == 1, 32'hC000_0000 + $urandom_range(0, 95) * 64,
           $urandom_range(0, 1) == 1, 32'hC000_0000 + $urandom_range(0, 95) * 64,
           "R3,R5,R6 random mix");
    idle(4);
    check("R2 all verdicts returned", q_hit.size(), 0);

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule